// File: doc/BRIEF.md
# Ethernet Controller Register Bank

This block is the 32-bit control and status register file that sits in front of a gigabit Ethernet MAC and its DMA engine. A host reaches it through a simple valid/ready register port: each accepted request is a single word access decoded from a 13-bit byte offset inside an 8 KiB window. Reads return their data one cycle after the request.

The bank loads documented cold defaults on reset. A self-clearing software-reset bit in the DMA bus-mode register restores those defaults at any time. The bank applies per-register access rules. Some registers are read-only. Two poll-demand registers are write-only. The MAC configuration word drops every write. Each ordinary word, and each unnamed offset below the end of the register space, behaves as plain read/write storage.

The primary station address is assembled from a high/low register pair and driven out continuously as a 48-bit value. The consuming logic (frame filtering, transmit, receive, DMA) lives elsewhere.

Top module: `eth_regbank`

## Requirements
- R1: After reset these reads return the stated values: offset 0x20 returns 0x00001032. Offset 0x34 returns 0x03E80000. Offset 0x40 returns 0x8000FFFF. Offsets 0x48, 0x50 and 0x58 return 0x0000FFFF. Offsets 0x44, 0x4C, 0x54 and 0x5C return 0xFFFFFFFF. Offset 0x700 returns 0x00002000. Offset 0x1000 returns 0x00020100. Offset 0x1058 returns 0x100D4F37. Every other offset returns 0.
- R2: req_ready is always 1. A read accepted in cycle N drives rd_valid high with its data in cycle N+1. A write to an ordinary offset is visible to any later read.
- R3: A write to any of the following offsets leaves its value unchanged: 0x20, 0x38, 0xD8, 0x708, 0x70C, 0x1020, 0x1048, 0x104C, 0x1050, 0x1054, 0x1058.
- R4: A read of offset 0x1004 or 0x1008 returns 0. A write to either offset has no visible effect and raises no error.
- R5: A write to offset 0x000 is discarded, and later reads of it return 0. The write raises no error.
- R6: A write to offset 0x1000 with bit 0 set restores every register to its R1 value by the next cycle, so bit 0 reads back as 0. A write there with bit 0 clear is stored as written.
- R7: station_addr[47:32] equals bits 15:0 of offset 0x40, and station_addr[31:0] equals offset 0x44. Address byte 0 is therefore station_addr[47:40]. A write to either register shows on the output one cycle later.
- R8: Writes to offsets 0x48 to 0x5C are stored and read back, but they do not change station_addr.
- R9: An offset at or above 0x1060 inside the window reads 0 and ignores writes, with no error. An aligned offset below 0x1060 that is not named elsewhere acts as plain storage.
- R10: A request whose offset bits 1:0 are not both zero writes nothing, reads 0 and raises no error.
- R11: err_pulse is high for exactly the one cycle after an accepted aligned write to an R3 offset, or after an accepted aligned read of an R4 offset. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 13 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Always 1; the bank accepts one access per cycle |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| err_pulse | output | 1 | One-cycle access-rule violation flag |
| station_addr | output | 48 | Primary station address, byte 0 in the top bits |

## Verification
The assertions assume that req_valid is low while rst_n is low. They also assume that every input is stable across the sampling edge, so that each $past term refers to a real accepted request. The stimulus meets both assumptions: it holds the port idle through reset and changes inputs only a short delay after each rising edge. After a directed pass over each register class, a pseudo-random mix of reads and writes runs over named, unnamed, out-of-range and misaligned offsets. Software resets appear in that mix, so the restore path is exercised while other registers hold non-default data.

// File: rtl/eth_regbank_pkg.sv
package eth_regbank_pkg;
  localparam int unsigned OFF_CFG      = 'h000;
  localparam int unsigned OFF_VER      = 'h020;
  localparam int unsigned OFF_TMR      = 'h034;
  localparam int unsigned OFF_MSTAT    = 'h038;
  localparam int unsigned OFF_ST_HI    = 'h040;
  localparam int unsigned OFF_ST_LO    = 'h044;
  localparam int unsigned OFF_SLOT_FST = 'h048;
  localparam int unsigned OFF_SLOT_LST = 'h05C;
  localparam int unsigned OFF_LSTAT    = 'h0D8;
  localparam int unsigned OFF_TSCTL    = 'h700;
  localparam int unsigned OFF_TSSEC    = 'h708;
  localparam int unsigned OFF_TSNS     = 'h70C;
  localparam int unsigned OFF_BUSMODE  = 'h1000;
  localparam int unsigned OFF_TXPOLL   = 'h1004;
  localparam int unsigned OFF_RXPOLL   = 'h1008;
  localparam int unsigned OFF_MISSED   = 'h1020;
  localparam int unsigned OFF_CURDESC0 = 'h1048;
  localparam int unsigned OFF_CURBUF1  = 'h1054;
  localparam int unsigned OFF_FEATURE  = 'h1058;

  localparam logic [31:0] DEF_BUSMODE = 32'h0002_0100;

  // Cold default of a word, selected by its byte offset.
  function automatic logic [31:0] word_default(input int unsigned idx);
    int unsigned off;
    off = idx * 4;
    if (off == OFF_VER)                               return 32'h0000_1032;
    if (off == OFF_TMR)                               return 32'h03E8_0000;
    if (off == OFF_ST_HI)                             return 32'h8000_FFFF;
    if (off >= OFF_ST_HI && off <= OFF_SLOT_LST)
      return off[2] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (off == OFF_TSCTL)                             return 32'h0000_2000;
    if (off == OFF_BUSMODE)                           return DEF_BUSMODE;
    if (off == OFF_FEATURE)                           return 32'h100D_4F37;
    return 32'h0;
  endfunction

  function automatic logic is_read_only(input int unsigned off);
    return (off == OFF_VER) || (off == OFF_MSTAT) || (off == OFF_LSTAT) ||
           (off == OFF_TSSEC) || (off == OFF_TSNS) || (off == OFF_MISSED) ||
           (off >= OFF_CURDESC0 && off <= OFF_FEATURE);
  endfunction

  function automatic logic [47:0] pack_station(input logic [15:0] hi16,
                                               input logic [31:0] lo);
    return {hi16[15:8], hi16[7:0], lo[31:24], lo[23:16], lo[15:8], lo[7:0]};
  endfunction
endpackage

// File: rtl/eth_regbank_decode.sv
module eth_regbank_decode
  import eth_regbank_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int NUM_WORDS = 1048,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              aligned,
  output logic              in_range,
  output logic              is_ro,
  output logic              is_wo,
  output logic              is_cfg,
  output logic              is_busmode,
  output logic              is_slot
);
  int unsigned off;

  always_comb begin
    off        = int'(addr);
    word_idx   = addr[ADDR_W-1:2];
    aligned    = (addr[1:0] == 2'b00);
    in_range   = (off < NUM_WORDS * 4);
    is_ro      = is_read_only(off);
    is_wo      = (off == OFF_TXPOLL) || (off == OFF_RXPOLL);
    is_cfg     = (off == OFF_CFG);
    is_busmode = (off == OFF_BUSMODE);
    is_slot    = (off >= OFF_SLOT_FST) && (off <= OFF_SLOT_LST);
  end
endmodule

// File: rtl/eth_regbank_store.sv
module eth_regbank_store
  import eth_regbank_pkg::*;
#(
  parameter int NUM_WORDS = 1048,
  parameter int IDX_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  input  logic             rd_zero,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [15:0]      st_hi16,
  output logic [31:0]      st_lo
);
  localparam int HI_IDX = OFF_ST_HI / 4;
  localparam int LO_IDX = OFF_ST_LO / 4;
  localparam int BM_IDX = OFF_BUSMODE / 4;
  localparam int VR_IDX = OFF_VER / 4;

  logic [31:0] mem [NUM_WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= word_default(i);
    end else if (sw_reset) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= word_default(i);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_zero ? 32'h0 : mem[rd_idx];
    end
  end

  assign st_hi16 = mem[HI_IDX][15:0];
  assign st_lo   = mem[LO_IDX];

  assert_swreset_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (mem[BM_IDX] == DEF_BUSMODE) && (mem[VR_IDX] == 32'h0000_1032)
                 && (mem[LO_IDX] == 32'hFFFF_FFFF));
endmodule

// File: rtl/eth_regbank_station.sv
module eth_regbank_station
  import eth_regbank_pkg::*;
(
  input  logic [15:0] hi16,
  input  logic [31:0] lo,
  output logic [47:0] station
);
  assign station = pack_station(hi16, lo);
endmodule

// File: rtl/eth_regbank.sv
module eth_regbank
  import eth_regbank_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int NUM_WORDS = 1048,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              err_pulse,
  output logic [47:0]       station_addr
);
  logic [IDX_W-1:0] dec_idx;
  logic dec_aligned, dec_in_range, dec_ro, dec_wo, dec_cfg, dec_bm, dec_slot;
  logic acc_write, acc_read, sw_reset, commit_wr, rule_err, rd_zero;
  logic [15:0] st_hi16;
  logic [31:0] st_lo;

  assign req_ready = 1'b1;

  eth_regbank_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
    .addr(req_addr), .word_idx(dec_idx), .aligned(dec_aligned),
    .in_range(dec_in_range), .is_ro(dec_ro), .is_wo(dec_wo), .is_cfg(dec_cfg),
    .is_busmode(dec_bm), .is_slot(dec_slot));

  // Named access events
  assign acc_write = req_valid && req_write && dec_aligned && dec_in_range;
  assign acc_read  = req_valid && !req_write;
  assign sw_reset  = acc_write && dec_bm && req_wdata[0];
  assign commit_wr = acc_write && !dec_ro && !dec_wo && !dec_cfg && !sw_reset;
  assign rd_zero   = !dec_aligned || !dec_in_range || dec_wo;
  assign rule_err  = req_valid && dec_aligned &&
                     ((req_write && dec_ro) || (!req_write && dec_wo));

  eth_regbank_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .wr_en(commit_wr),
    .wr_idx(dec_idx), .wr_data(req_wdata), .rd_en(acc_read), .rd_zero(rd_zero),
    .rd_idx(dec_idx), .rd_valid(rd_valid), .rd_data(rd_data),
    .st_hi16(st_hi16), .st_lo(st_lo));

  eth_regbank_station u_station (.hi16(st_hi16), .lo(st_lo), .station(station_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_pulse <= 1'b0;
    else        err_pulse <= rule_err;
  end

  assert_wo_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && dec_aligned && dec_wo) |=> (rd_valid && rd_data == 32'h0));
  assert_cfg_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && dec_cfg) |=> (rd_data == 32'h0));
  assert_slot_keeps_station_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && dec_aligned && dec_slot) |=> $stable(station_addr));
  assert_err_needs_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid));
  assert_misaligned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dec_aligned) |=> !err_pulse);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
endmodule

// File: tb/eth_regbank_bench.sv
module eth_regbank_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [12:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rd_valid, err_pulse;
  logic [31:0] rd_data;
  logic [47:0] station_addr;
  int checks = 0, fails = 0;
  bit [31:0] shadow [int];
  bit done = 0;

  always #10 clk = ~clk;

  eth_regbank u_eth_regbank (.clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_pulse(err_pulse), .station_addr(station_addr));

  function automatic bit [31:0] cold(int off);
    case (off)
      'h20: return 32'h00001032;   'h34: return 32'h03E80000;
      'h40: return 32'h8000FFFF;   'h48, 'h50, 'h58: return 32'h0000FFFF;
      'h44, 'h4C, 'h54, 'h5C: return 32'hFFFFFFFF;
      'h700: return 32'h00002000;  'h1000: return 32'h00020100;
      'h1058: return 32'h100D4F37;
      default: return 0;
    endcase
  endfunction
  function automatic bit [31:0] mget(int off);
    return shadow.exists(off) ? shadow[off] : cold(off);
  endfunction
  function automatic bit ro(int off);
    int lst[11] = '{'h20,'h38,'hD8,'h708,'h70C,'h1020,'h1048,'h104C,'h1050,'h1054,'h1058};
    foreach (lst[i]) if (lst[i] == off) return 1;
    return 0;
  endfunction
  function automatic bit wo(int off); return off == 'h1004 || off == 'h1008; endfunction
  function automatic string tag_of(int off, bit wr, bit [31:0] d);
    if (off[1:0] != 0) return "R10";
    if (off >= 'h1060) return "R9";
    if (wo(off)) return "R4";
    if (wr && ro(off)) return "R3";
    if (off == 0) return "R5";
    if (off == 'h1000 && wr) return "R6";
    if (off >= 'h48 && off <= 'h5C) return "R8";
    if (off == 'h40 || off == 'h44) return "R7";
    if (d == 32'hdead_0000) return "R1";
    return "R2";
  endfunction

  task automatic chk(bit ok, string tag, string what, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic op(bit wr, int off, bit [31:0] d, string tg = "");
    bit exp_rv, exp_err; bit [31:0] exp_rd; bit [47:0] exp_st; string t;
    t = (tg == "") ? tag_of(off, wr, d) : tg;
    req_valid = 1; req_write = wr; req_addr = 13'(off); req_wdata = d;
    @(posedge clk);
    exp_rv = !wr; exp_err = 0; exp_rd = 0;
    if (!wr) begin
      exp_rd  = (off[1:0] != 0 || off >= 'h1060 || wo(off)) ? 0 : mget(off);
      exp_err = (off[1:0] == 0) && wo(off);
    end else if (off[1:0] == 0 && off < 'h1060) begin
      if (ro(off)) exp_err = 1;
      else if (wo(off) || off == 0) ;
      else if (off == 'h1000 && d[0]) shadow.delete();
      else shadow[off] = d;
    end
    exp_st = {mget('h40) & 32'hFFFF, mget('h44)};
    exp_st = {exp_st[47:32], mget('h44)};
    #2;
    req_valid = 0;
    chk(req_ready === 1'b1, "R2", "req_ready", 64'(req_ready), 1);
    chk(rd_valid === exp_rv, {"R2/", t}, "rd_valid", 64'(rd_valid), 64'(exp_rv));
    if (exp_rv) chk(rd_data === exp_rd, t, "rd_data", 64'(rd_data), 64'(exp_rd));
    chk(err_pulse === exp_err, {"R11/", t}, "err_pulse", 64'(err_pulse), 64'(exp_err));
    chk(station_addr === exp_st, "R7", "station_addr", 64'(station_addr), 64'(exp_st));
  endtask

  task automatic idle();
    @(posedge clk); #2;
    chk(rd_valid === 0 && err_pulse === 0, "R11", "idle outputs",
        64'({rd_valid, err_pulse}), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    int pool[22] = '{'h0,'h20,'h34,'h38,'h40,'h44,'h48,'h4C,'h5C,'h100,'h700,'h708,
                     'h1000,'h1004,'h1008,'h1018,'h1058,'h1060,'h1FFC,'h102,'h41,'hD8};
    repeat (3) @(posedge clk);
    #2;
    chk(rd_valid === 0 && err_pulse === 0, "R1", "reset outputs", 64'({rd_valid, err_pulse}), 0);
    rst_n = 1;
    // R1 cold defaults
    foreach (pool[i]) if (pool[i][1:0] == 0 && pool[i] < 'h1060) op(0, pool[i], 0, "R1");
    op(0, 'h50, 0, "R1"); op(0, 'h54, 0, "R1"); op(0, 'h58, 0, "R1");
    chk(station_addr === 48'hFFFF_FFFF_FFFF, "R1", "station default", 64'(station_addr), 48'hFFFF_FFFF_FFFF);
    // R2 plain storage and back-to-back reads
    op(1, 'h100, 32'h1234_5678); op(0, 'h100, 0); op(0, 'h100, 0);
    op(1, 'h1018, 32'hA5A5_0F0F); op(0, 'h1018, 0);
    // R3 read-only
    op(1, 'h20, 32'hFFFF_FFFF); op(0, 'h20, 0, "R3");
    op(1, 'h1058, 0); op(0, 'h1058, 0, "R3");
    // R4 write-only
    op(1, 'h1004, 32'h1); op(0, 'h1004, 0); op(0, 'h1008, 0); idle();
    // R5 config discard
    op(1, 'h0, 32'hCAFE_F00D); op(0, 'h0, 0);
    // R7 station packing
    op(1, 'h40, 32'h0000_0211); op(1, 'h44, 32'h2233_4455);
    chk(station_addr === 48'h0211_2233_4455, "R7", "station pack", 64'(station_addr), 48'h0211_2233_4455);
    // R8 other slots
    op(1, 'h48, 32'h0000_AAAA); op(1, 'h5C, 32'h1111_1111); op(0, 'h48, 0); op(0, 'h5C, 0);
    // R9 above range, unnamed inside
    op(1, 'h1FFC, 32'h7); op(0, 'h1FFC, 0); op(1, 'h1060, 32'h9); op(0, 'h1060, 0);
    op(1, 'hE00, 32'h55); op(0, 'hE00, 0, "R9");
    // R10 misaligned
    op(1, 'h102, 32'hFFFF_FFFF); op(0, 'h100, 0, "R10"); op(0, 'h1006, 0);
    // R6 bus mode without and with reset bit
    op(1, 'h1000, 32'h0000_0F00); op(0, 'h1000, 0, "R6");
    op(1, 'h1000, 32'h0000_0001); op(0, 'h1000, 0, "R6"); op(0, 'h100, 0, "R6");
    op(0, 'h48, 0, "R6");
    chk(station_addr === 48'hFFFF_FFFF_FFFF, "R6", "station restored", 64'(station_addr), 48'hFFFF_FFFF_FFFF);
    // mixed pseudo-random traffic
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      op(lf[3], pool[lf[12:8] % 22], (lf[20:16] == 0) ? lf : {lf[31:1], 1'b0});
      if (lf[27:25] == 0) idle();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule